// File: doc/BRIEF.md
# Auto-Prefetching Bus Read Accelerator

This engine takes block reads off a small processor core. The core arms it with one two-word write: a short mode word and a start address. The engine then fetches a block of 4, 32 or 64 bytes over a simple request/response memory bus. The data lands in a holding buffer. The core polls a status word. When the data is ready, the core takes the whole buffer in a single cycle over a wide parallel port.

In auto mode, every time the core takes the buffer the engine launches the next read, at an address advanced by the block size. The memory access therefore overlaps the core's work on the block it just took, and only the first read of a sequence is waited on. Arming the engine never starts a transfer by itself. The first take after arming drops whatever was buffered and starts read one at the new address. If the engine is re-armed while a finished block is still unread, the next take hands over that block and starts the new sequence in the same cycle. In manual mode a separate trigger pulse starts each read.

Top module: `burst_prefetch_eng`

## Requirements
- R1: After reset the status word, the data port and `req_valid` are all zero.
- R2: A configuration write (`cfg_wr`) issues no memory request. It sets the armed flag (status bit 11) and leaves the data-valid flag (status bit 9) unchanged.
- R3: In auto mode (`cfg_word[0]`=1), the first drain after a configuration write issues one request at the configured start address. Its byte count follows `cfg_word[2:1]`: 00 or 01 gives 4, 10 gives 32, 11 gives 64.
- R4: While a read is pending or in flight, status bit 10 (busy) is 1 and bit 9 is 0. Once the block has arrived, bit 9 is 1 and status[7:0] equals `cfg_word[2:0]` zero-extended, so 5 means auto mode with 32 bytes. While the data is not valid, status[7:0] is 0.
- R5: When valid, `rd_data` word i (bits 32i+31..32i) holds response beat i. Words beyond the block size read as zero.
- R6: In auto mode, a drain while data is valid returns the block on `rd_data` during the drain cycle. It also issues the next request at the previous request address plus the block size.
- R7: If the engine is re-armed while a block is still valid, the next drain returns that block and issues a request at the new start address.
- R8: In manual mode (`cfg_word[0]`=0), a drain never issues a request. Each `kick` pulse issues one request at the configured address, and the address does not advance.
- R9: A drain while data is not valid and the engine is not armed returns the previous buffer contents and issues no request. It sets status bit 8 (underflow), which stays set until the next configuration write clears it.
- R10: While `req_valid` is high and `req_ready` is low, the request stays asserted with its address and byte count unchanged.
- R11: Data valid rises only after the last response beat, whatever gaps the memory leaves between beats.
- R12: In auto mode `kick` is ignored: no request is issued and the valid data is undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe (mode word plus address) |
| cfg_word | input | 3 | Mode bits: [0] auto enable, [2:1] size code |
| cfg_addr | input | 32 | Start address of the sequence |
| drain | input | 1 | Core takes the buffer this cycle |
| kick | input | 1 | Manual-mode read trigger |
| status | output | 16 | [7:0] mode echo when valid, [8] underflow, [9] valid, [10] busy, [11] armed |
| rd_data | output | 512 | Broadside view of the data buffer |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Request byte address |
| req_bytes | output | 7 | Request byte count (4, 32 or 64) |
| rsp_valid | input | 1 | Response beat present |
| rsp_data | input | 32 | Response beat data |

## Verification
The assertions check on every cycle that a stalled request holds its address and count, that only legal byte counts are requested, and that data valid rises only right after a response beat. They also check that the underflow flag stays set until a configuration write and that the buffer changes only on a completing beat. Only the bench scenarios can show which address and size each drain or kick actually fetches. The same is true of the re-arm handover of the final block, the zero fill above small blocks, and the absence of any request after an ignored trigger or an underflowing drain.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
    localparam int MAX_BYTES = 64;
    localparam int BYTES_W   = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2
    } eng_state_e;

    function automatic logic [BYTES_W-1:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b10:   return BYTES_W'(32);
            2'b11:   return BYTES_W'(64);
            default: return BYTES_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/bpe_ctrl.sv
module bpe_ctrl
    import bpe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_wr,
    input  logic [2:0]                      cfg_word,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic                            drain,
    input  logic                            kick,
    input  logic                            req_ready,
    input  logic                            rsp_valid,
    output logic                            req_valid,
    output logic [ADDR_W-1:0]               req_addr,
    output logic [BYTES_W-1:0]              req_bytes,
    output logic                            fill_clear,
    output logic                            fill_we,
    output logic [$clog2(MAX_BYTES*8/BEAT_W)-1:0] fill_idx,
    output logic                            commit,
    output logic [15:0]                     status
);
    localparam int BEAT_BYTES = BEAT_W / 8;
    localparam int MAX_BEATS  = MAX_BYTES / BEAT_BYTES;
    localparam int IDX_W      = $clog2(MAX_BEATS);

    typedef struct packed {
        eng_state_e          st;
        logic                auto_en;
        logic [1:0]          size;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   lat_addr;
        logic [BYTES_W-1:0]  lat_bytes;
        logic [IDX_W:0]      beat;
        logic                armed;
        logic                valid;
        logic                under;
        logic                pend;
    } ctrl_t;

    ctrl_t q, d;
    logic [IDX_W:0] last_beat;

    always_comb begin
        d          = q;
        fill_clear = 1'b0;
        fill_we    = 1'b0;
        commit     = 1'b0;
        last_beat  = (IDX_W+1)'(int'(q.lat_bytes) / BEAT_BYTES - 1);

        // take of the buffer by the core
        if (drain) begin
            if (q.armed) begin
                d.armed = 1'b0;
                d.valid = 1'b0;
                if (q.auto_en) d.pend = 1'b1;
            end else if (q.valid) begin
                d.valid = 1'b0;
                if (q.auto_en) d.pend = 1'b1;
            end else begin
                d.under = 1'b1;
            end
        end

        // transfer sequencing
        case (q.st)
            ST_IDLE: begin
                if (q.pend) begin
                    d.pend      = 1'b0;
                    d.lat_addr  = q.addr;
                    d.lat_bytes = size_bytes(q.size);
                    if (q.auto_en) d.addr = q.addr + ADDR_W'(size_bytes(q.size));
                    d.st        = ST_REQ;
                    fill_clear  = 1'b1;
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    d.st   = ST_RESP;
                    d.beat = '0;
                end
            end
            ST_RESP: begin
                if (rsp_valid) begin
                    fill_we = 1'b1;
                    if (q.beat == last_beat) begin
                        commit  = 1'b1;
                        d.valid = 1'b1;
                        d.st    = ST_IDLE;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // manual trigger
        if (kick && !q.auto_en) d.pend = 1'b1;

        // arming write wins over everything else this cycle
        if (cfg_wr) begin
            d.auto_en = cfg_word[0];
            d.size    = cfg_word[2:1];
            d.addr    = cfg_addr;
            d.armed   = 1'b1;
            d.under   = 1'b0;
            d.pend    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fill_idx  = q.beat[IDX_W-1:0];
    assign req_valid = (q.st == ST_REQ);
    assign req_addr  = q.lat_addr;
    assign req_bytes = q.lat_bytes;
    assign status    = {4'b0, q.armed, (q.st != ST_IDLE) || q.pend, q.valid, q.under,
                        q.valid ? {5'b0, q.size, q.auto_en} : 8'h00};

    // R10: a stalled request must not move
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_bytes));

    // R3: only the three supported transfer sizes are ever requested
    a_r3_legal_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_bytes == BYTES_W'(4) || req_bytes == BYTES_W'(32) || req_bytes == BYTES_W'(64)));

    // R11: data valid follows a response beat
    a_r11_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[9]) |-> $past(rsp_valid));

    // R9: underflow is sticky until re-armed
    a_r9_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[8] && !cfg_wr |=> status[8]);

    // R2: an arming write leaves the engine armed
    a_r2_armed: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> status[11]);
endmodule

// File: rtl/bpe_buffer.sv
module bpe_buffer #(
    parameter int BEAT_W = 32,
    parameter int WORDS  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       we,
    input  logic [$clog2(WORDS)-1:0]   idx,
    input  logic [BEAT_W-1:0]          wdata,
    input  logic                       commit,
    output logic [WORDS*BEAT_W-1:0]    data
);
    typedef struct packed {
        logic [WORDS-1:0][BEAT_W-1:0] fill;
        logic [WORDS-1:0][BEAT_W-1:0] hold;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clear) d.fill = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (we && idx == $clog2(WORDS)'(i)) d.fill[i] = wdata;
        end
        if (commit) d.hold = d.fill;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_out
        assign data[gi*BEAT_W +: BEAT_W] = q.hold[gi];
    end

    // R9: the visible buffer only changes when a block completes
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(data));
endmodule

// File: rtl/burst_prefetch_eng.sv
module burst_prefetch_eng
    import bpe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [2:0]               cfg_word,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic                     drain,
    input  logic                     kick,
    output logic [15:0]              status,
    output logic [MAX_BYTES*8-1:0]   rd_data,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [BYTES_W-1:0]       req_bytes,
    input  logic                     rsp_valid,
    input  logic [BEAT_W-1:0]        rsp_data
);
    localparam int WORDS = MAX_BYTES * 8 / BEAT_W;
    localparam int IDX_W = $clog2(WORDS);

    logic             fill_clear, fill_we, commit;
    logic [IDX_W-1:0] fill_idx;

    bpe_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word), .cfg_addr(cfg_addr),
        .drain(drain), .kick(kick),
        .req_ready(req_ready), .rsp_valid(rsp_valid),
        .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes),
        .fill_clear(fill_clear), .fill_we(fill_we), .fill_idx(fill_idx),
        .commit(commit), .status(status)
    );

    bpe_buffer #(.BEAT_W(BEAT_W), .WORDS(WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear(fill_clear), .we(fill_we), .idx(fill_idx), .wdata(rsp_data),
        .commit(commit), .data(rd_data)
    );
endmodule

// File: tb/sim_burst_prefetch_eng.sv
module sim_burst_prefetch_eng;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, drain = 1'b0, kick = 1'b0;
    logic [2:0] cfg_word = '0;
    logic [31:0] cfg_addr = '0;
    logic [15:0] status;
    logic [511:0] rd_data;
    logic req_valid, req_ready = 1'b1;
    logic [31:0] req_addr;
    logic [6:0] req_bytes;
    logic rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    burst_prefetch_eng u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word), .cfg_addr(cfg_addr),
        .drain(drain), .kick(kick), .status(status), .rd_data(rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_bytes(req_bytes),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] memw(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic logic [511:0] exp_block(input logic [31:0] a, input int nbytes);
        logic [511:0] r = '0;
        for (int i = 0; i < 16; i++)
            if (i < nbytes / 4) r[i*32 +: 32] = memw(a + 32'(4 * i));
        return r;
    endfunction

    // memory model
    int req_count = 0;
    logic [31:0] last_addr = '0;
    int last_bytes = 0;
    bit m_active = 0;
    int m_beats = 0, m_idx = 0, m_wait = 0;
    int lat_cfg = 2, gap_cfg = 0;

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (m_active) begin
            if (m_wait > 0) begin
                m_wait--;
            end else begin
                rsp_valid = 1'b1;
                rsp_data  = memw(last_addr + 32'(4 * m_idx));
                m_idx++;
                m_wait = gap_cfg;
                if (m_idx == m_beats) m_active = 0;
            end
        end
        if (rst_n && req_valid && req_ready && !m_active) begin
            req_count++;
            last_addr  = req_addr;
            last_bytes = int'(req_bytes);
            m_beats    = int'(req_bytes) / 4;
            m_idx      = 0;
            m_wait     = lat_cfg;
            m_active   = 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_blk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_cfg(input logic [2:0] w, input logic [31:0] a);
        cfg_word = w; cfg_addr = a; cfg_wr = 1'b1;
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic do_drain(output logic [511:0] got);
        drain = 1'b1;
        #1 got = rd_data;
        @(negedge clk) drain = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid(input string tag);
        int n = 0;
        while (!status[9] && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " valid reached"}, 64'(status[9]), 64'd1);
        chk("R11 valid only after last beat", 64'(m_active), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 status", 64'(status), 64'd0);
        chk("R1 req_valid", 64'(req_valid), 64'd0);
        chk_blk("R1 rd_data", rd_data, '0);
    endtask

    task automatic t_arm();
        int c0 = req_count;
        do_cfg(3'b101, 32'h1000);
        idle(5);
        chk("R2 no request", 64'(req_count), 64'(c0));
        chk("R2 armed", 64'(status[11]), 64'd1);
        chk("R2 valid unchanged", 64'(status[9]), 64'd0);
    endtask

    task automatic t_auto_seq(output logic [31:0] last_a);
        logic [511:0] got;
        int c0 = req_count;
        logic [31:0] a;
        lat_cfg = 3; gap_cfg = 1;
        do_drain(got);
        chk("R4 busy while pending", 64'(status[10]), 64'd1);
        chk("R4 not valid while pending", 64'(status[9]), 64'd0);
        chk("R4 low byte zero while pending", 64'(status[7:0]), 64'd0);
        wait_valid("R3");
        chk("R3 one request", 64'(req_count), 64'(c0 + 1));
        chk("R3 start address", 64'(last_addr), 64'h1000);
        chk("R3 size 32", 64'(last_bytes), 64'd32);
        chk("R4 low byte echo", 64'(status[7:0]), 64'd5);
        chk("R4 busy clear", 64'(status[10]), 64'd0);
        chk_blk("R5 block data", rd_data, exp_block(32'h1000, 32));
        a = 32'h1000;
        for (int k = 1; k <= 3; k++) begin
            gap_cfg = (k == 2) ? 3 : 0;
            do_drain(got);
            chk_blk("R6 drain returns block", got, exp_block(a, 32));
            a = a + 32'd32;
            wait_valid("R6");
            chk("R6 advanced address", 64'(last_addr), 64'(a));
            chk_blk("R6 next block", rd_data, exp_block(a, 32));
        end
        chk("R6 request count", 64'(req_count), 64'(c0 + 4));
        last_a = a;
    endtask

    task automatic t_rearm(input logic [31:0] prev_a);
        logic [511:0] got;
        int c0 = req_count;
        gap_cfg = 0;
        do_cfg(3'b101, 32'h2000);
        idle(3);
        chk("R7 still valid after re-arm", 64'(status[9]), 64'd1);
        chk("R7 no request on re-arm", 64'(req_count), 64'(c0));
        do_drain(got);
        chk_blk("R7 final block delivered", got, exp_block(prev_a, 32));
        wait_valid("R7");
        chk("R7 new start address", 64'(last_addr), 64'h2000);
        chk_blk("R7 new block", rd_data, exp_block(32'h2000, 32));
    endtask

    task automatic t_underflow();
        logic [511:0] got, got2;
        int c0 = req_count;
        lat_cfg = 4;
        do_drain(got);
        do_drain(got2);
        chk_blk("R9 underflow returns previous", got2, exp_block(32'h2000, 32));
        chk("R9 underflow flag", 64'(status[8]), 64'd1);
        wait_valid("R9");
        chk("R9 no extra request", 64'(req_count), 64'(c0 + 1));
        chk("R9 address of real read", 64'(last_addr), 64'h2020);
        chk("R9 sticky", 64'(status[8]), 64'd1);
        do_cfg(3'b101, 32'h3000);
        chk("R9 cleared by config", 64'(status[8]), 64'd0);
    endtask

    task automatic t_manual();
        logic [511:0] got;
        int c0;
        lat_cfg = 2; gap_cfg = 1;
        do_cfg(3'b110, 32'h4000);
        c0 = req_count;
        do_drain(got);
        idle(6);
        chk("R8 armed drain no request", 64'(req_count), 64'(c0));
        do_kick();
        wait_valid("R8");
        chk("R8 kick address", 64'(last_addr), 64'h4000);
        chk("R8 size 64", 64'(last_bytes), 64'd64);
        chk("R4 low byte manual 64", 64'(status[7:0]), 64'd6);
        chk_blk("R5 64-byte block", rd_data, exp_block(32'h4000, 64));
        c0 = req_count;
        do_drain(got);
        idle(6);
        chk("R8 valid drain no request", 64'(req_count), 64'(c0));
        chk("R8 valid cleared", 64'(status[9]), 64'd0);
        do_kick();
        wait_valid("R8");
        chk("R8 address not advanced", 64'(last_addr), 64'h4000);
        do_drain(got);
        do_cfg(3'b000, 32'h5000);
        do_kick();
        wait_valid("R8");
        chk("R3 size code 00", 64'(last_bytes), 64'd4);
        chk("R4 low byte manual 4", 64'(status[7:0]), 64'd0);
        chk_blk("R5 upper words zero", rd_data, exp_block(32'h5000, 4));
    endtask

    task automatic t_kick_auto();
        logic [511:0] got;
        int c0;
        gap_cfg = 0;
        do_cfg(3'b111, 32'h6000);
        do_drain(got);
        wait_valid("R12");
        c0 = req_count;
        do_kick();
        idle(8);
        chk("R12 kick ignored", 64'(req_count), 64'(c0));
        chk("R12 still valid", 64'(status[9]), 64'd1);
        chk_blk("R12 data untouched", rd_data, exp_block(32'h6000, 64));
    endtask

    task automatic t_ready_stall();
        logic [511:0] got;
        int c0 = req_count;
        req_ready = 1'b0;
        do_drain(got);
        idle(5);
        chk("R10 request held", 64'(req_valid), 64'd1);
        chk("R10 address held", 64'(req_addr), 64'h6040);
        chk("R10 bytes held", 64'(req_bytes), 64'd64);
        chk("R10 not accepted", 64'(req_count), 64'(c0));
        req_ready = 1'b1;
        wait_valid("R10");
        chk_blk("R10 block after stall", rd_data, exp_block(32'h6040, 64));
    endtask

    initial begin
        logic [31:0] la;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_auto_seq(la);
        t_rearm(la);
        t_underflow();
        t_manual();
        t_kick_auto();
        t_ready_stall();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule